// File: doc/BRIEF.md
# UART Receive Byte Queue with Status

This block sits between a serial receiver and a register-read port. Each received byte arrives as a one-cycle strobe and goes into a circular queue. The queue holds `DEPTH` entries, 16 by default. Software reads four things through one read port: the head byte, a queue status word, a sticky error word that clears when read, and a line-status word. When the queue is turned off, the block falls back to a single holding register.

A break strobe stores a null byte and marks a break error. When a byte arrives at a full queue, the byte is dropped and marked as an overrun. Reading an empty queue returns zero. Each of these faults, and each parity or framing flag from the receiver, gives a one-cycle error interrupt-source pulse. Every stored data byte gives a one-cycle receive interrupt-source pulse. A clear strobe empties the queue.

Top module: `rxq_top`

## Requirements
- R1: After reset the queue is empty, `data_ready` is 0, the queue status word reads 0 and the error word reads 0.
- R2: Bytes leave the queue in arrival order. A read with `rd_en` high and `rd_sel`=0 returns the head byte on `rd_data` in the cycle after the edge that samples it. `rd_sel`=1 returns the queue status word, whose bits [7:0] hold the fill count.
- R3: When the queue holds `DEPTH` bytes, status bit 8 (full) is 1 and bits [7:0] read as zero.
- R4: A byte strobed into a full queue, with no read in the same cycle, is dropped. It sets error bit 0 (overrun) and pulses `irq_err_pulse` in the next cycle. `data_ready` stays 1.
- R5: A data read (`rd_sel`=0) from an empty, enabled queue returns 0 and pulses `irq_err_pulse` in the next cycle.
- R6: While the queue is enabled, `data_ready` is 1 whenever bytes remain, and it clears when the last byte is read.
- R7: With `fifo_en` low, a received byte loads a holding register and sets `data_ready`. A data read returns that register and clears `data_ready`. The queue is left untouched.
- R8: A break strobe stores 0x00 (it wins over a byte strobe in the same cycle), sets error bit 3 and pulses `irq_err_pulse`.
- R9: A byte strobe with `rx_par_err` sets error bit 1. A byte strobe with `rx_frm_err` sets error bit 2. Either flag pulses `irq_err_pulse`.
- R10: Reading the error word (`rd_sel`=2) returns its value and clears it to zero; an error raised in that same cycle survives. Queue status bit 9 is 1 while the error word is nonzero.
- R11: A `fifo_clr` strobe empties the queue; a byte strobe in the same cycle is discarded.
- R12: A byte strobed into a full queue in the same cycle as a data read is accepted, and the count stays `DEPTH`.
- R13: Each stored data byte, in queue or holding mode, pulses `irq_rx_pulse` for one cycle in the next cycle; break bytes do not. `rd_sel`=3 returns `data_ready` in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_strobe | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| rx_par_err | input | 1 | Parity fault on the byte with rx_strobe |
| rx_frm_err | input | 1 | Framing fault on the byte with rx_strobe |
| brk_strobe | input | 1 | Break condition detected |
| fifo_en | input | 1 | 1: queue mode, 0: single holding register |
| fifo_clr | input | 1 | Empty the queue |
| rd_en | input | 1 | Read request |
| rd_sel | input | 2 | 0 data, 1 queue status, 2 error word, 3 line status |
| rd_data | output | 32 | Read result, valid the cycle after the request |
| data_ready | output | 1 | Received data is available |
| irq_rx_pulse | output | 1 | Receive interrupt source pulse |
| irq_err_pulse | output | 1 | Error interrupt source pulse |

## Verification
The bench fills the queue to exactly `DEPTH`, where a design that reported the raw count would show 16 in the count field instead of zero. It then strobes one more byte, which a design without an overrun guard would write over the oldest entry, and the drain order exposes that. A read combined with a write at full must keep the new byte; a design that checked full before counting the pop would drop it. Further cases cover an empty read that must return zero, a break byte, the clear-on-read error word, and holding mode, where a design that pushed into the queue would show a nonzero count.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef enum logic [1:0] {
    SEL_DATA  = 2'd0,
    SEL_FSTAT = 2'd1,
    SEL_ERR   = 2'd2,
    SEL_LINE  = 2'd3
  } rd_sel_e;

  localparam int ERR_W   = 4;
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;

  // queue status word: count field reads zero when full
  function automatic logic [31:0] fstat_word(input logic [7:0] cnt,
                                             input logic full,
                                             input logic err);
    return {22'd0, err, full, (full ? 8'd0 : cnt)};
  endfunction

  // sticky error word: read clears first, new events then set
  function automatic logic [ERR_W-1:0] err_next(input logic [ERR_W-1:0] cur,
                                                input logic clr,
                                                input logic [ERR_W-1:0] set);
    return (clr ? '0 : cur) | set;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [7:0]       din,
  input  logic             pop,
  output logic [7:0]       head,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= wrap_inc(wptr);
      if (pop)  rptr <= wrap_inc(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

endmodule

// File: rtl/rxq_errstat.sv
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic [ERR_W-1:0] set,
  output logic [ERR_W-1:0] err_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= err_next(err_q, rd_clr, set);
  end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_strobe,
  input  logic [7:0]  rx_byte,
  input  logic        rx_par_err,
  input  logic        rx_frm_err,
  input  logic        brk_strobe,
  input  logic        fifo_en,
  input  logic        fifo_clr,
  input  logic        rd_en,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        data_ready,
  output logic        irq_rx_pulse,
  output logic        irq_err_pulse
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]       head;
  logic [CNT_W-1:0] count;
  logic             full, empty;
  logic [ERR_W-1:0] err_q, err_set;
  logic [7:0]       hold_q;
  logic             hold_valid;
  rd_sel_e          sel;

  // named events
  logic       byte_in, rd_data_ev, rd_err_ev;
  logic       pop_ev, underflow_ev, push_req, push_ok, overrun_ev;
  logic       hold_load, hold_rd_ev, rx_store_ev, err_ev;
  logic [7:0] in_data;

  assign sel          = rd_sel_e'(rd_sel);
  assign byte_in      = rx_strobe | brk_strobe;
  assign in_data      = brk_strobe ? 8'h00 : rx_byte;
  assign rd_data_ev   = rd_en && (sel == SEL_DATA);
  assign rd_err_ev    = rd_en && (sel == SEL_ERR);
  assign pop_ev       = fifo_en && rd_data_ev && !empty && !fifo_clr;
  assign underflow_ev = fifo_en && rd_data_ev && empty;
  assign push_req     = fifo_en && byte_in && !fifo_clr;
  assign push_ok      = push_req && (!full || pop_ev);
  assign overrun_ev   = push_req && full && !pop_ev;
  assign hold_load    = !fifo_en && byte_in;
  assign hold_rd_ev   = !fifo_en && rd_data_ev;
  assign rx_store_ev  = (push_ok || hold_load) && !brk_strobe;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = overrun_ev;
    err_set[ERR_PAR] = rx_strobe && !brk_strobe && rx_par_err;
    err_set[ERR_FRM] = rx_strobe && !brk_strobe && rx_frm_err;
    err_set[ERR_BRK] = brk_strobe;
  end
  assign err_ev = underflow_ev || (err_set != '0);

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (push_ok),
    .din   (in_data),
    .pop   (pop_ev),
    .head  (head),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  rxq_errstat u_err (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_clr (rd_err_ev),
    .set    (err_set),
    .err_q  (err_q)
  );

  // holding register for queue-off mode
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= '0;
      hold_valid <= 1'b0;
    end else if (hold_load) begin
      hold_q     <= in_data;
      hold_valid <= 1'b1;
    end else if (hold_rd_ev) begin
      hold_valid <= 1'b0;
    end
  end

  assign data_ready = fifo_en ? !empty : hold_valid;

  logic [31:0] rd_next;
  always_comb begin
    case (sel)
      SEL_DATA: begin
        if (!fifo_en)   rd_next = {24'd0, hold_q};
        else if (empty) rd_next = '0;
        else            rd_next = {24'd0, head};
      end
      SEL_FSTAT: rd_next = fstat_word(8'(count), full, err_q != '0);
      SEL_ERR:   rd_next = {{(32-ERR_W){1'b0}}, err_q};
      default:   rd_next = {31'd0, data_ready};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data       <= '0;
      irq_rx_pulse  <= 1'b0;
      irq_err_pulse <= 1'b0;
    end else begin
      if (rd_en) rd_data <= rd_next;
      irq_rx_pulse  <= rx_store_ev;
      irq_err_pulse <= err_ev;
    end
  end

endmodule

// File: rtl/rxq_check.sv
module rxq_check
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fifo_en,
  input logic             fifo_clr,
  input logic             full,
  input logic [CNT_W-1:0] count,
  input logic             overrun_ev,
  input logic             underflow_ev,
  input logic             pop_ev,
  input logic             push_ok,
  input logic             rd_err_ev,
  input logic [ERR_W-1:0] err_set,
  input logic [ERR_W-1:0] err_q,
  input logic             hold_rd_ev,
  input logic             hold_load,
  input logic             rx_store_ev,
  input logic [31:0]      rd_data,
  input logic             data_ready,
  input logic             irq_rx_pulse,
  input logic             irq_err_pulse
);

  assert_full_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> (count == CNT_W'(DEPTH)));

  assert_overrun_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> (irq_err_pulse && err_q[ERR_OVR]));

  assert_underflow_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_ev |=> (rd_data == 32'd0 && irq_err_pulse));

  assert_hold_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_rd_ev && !hold_load) |=> (fifo_en || !data_ready));

  assert_err_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err_ev && err_set == '0) |=> (err_q == '0));

  assert_clr_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (count == '0));

  assert_swap_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && pop_ev && push_ok && !fifo_clr) |=> (count == CNT_W'(DEPTH)));

  assert_rx_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    rx_store_ev |=> irq_rx_pulse);

endmodule

bind rxq_top rxq_check #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fifo_en      (fifo_en),
  .fifo_clr     (fifo_clr),
  .full         (full),
  .count        (count),
  .overrun_ev   (overrun_ev),
  .underflow_ev (underflow_ev),
  .pop_ev       (pop_ev),
  .push_ok      (push_ok),
  .rd_err_ev    (rd_err_ev),
  .err_set      (err_set),
  .err_q        (err_q),
  .hold_rd_ev   (hold_rd_ev),
  .hold_load    (hold_load),
  .rx_store_ev  (rx_store_ev),
  .rd_data      (rd_data),
  .data_ready   (data_ready),
  .irq_rx_pulse (irq_rx_pulse),
  .irq_err_pulse(irq_err_pulse)
);

// File: tb/test_rxq_top.sv
`timescale 1ns/1ps
module test_rxq_top;

  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_strobe = 1'b0, rx_par_err = 1'b0, rx_frm_err = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        brk_strobe = 1'b0, fifo_en = 1'b1, fifo_clr = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = '0;
  logic [31:0] rd_data;
  logic        data_ready, irq_rx_pulse, irq_err_pulse;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  rxq_top #(.DEPTH(DEPTH)) i_rxq_top (
    .clk(clk), .rst_n(rst_n), .rx_strobe(rx_strobe), .rx_byte(rx_byte),
    .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .brk_strobe(brk_strobe),
    .fifo_en(fifo_en), .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .data_ready(data_ready),
    .irq_rx_pulse(irq_rx_pulse), .irq_err_pulse(irq_err_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // each task drives after a falling edge and returns at the next falling edge
  task automatic push(input logic [7:0] b, input logic par, input logic frm);
    @(negedge clk);
    rx_strobe = 1'b1; rx_byte = b; rx_par_err = par; rx_frm_err = frm;
    @(negedge clk);
    rx_strobe = 1'b0; rx_par_err = 1'b0; rx_frm_err = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = s;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic swap(input logic [7:0] b, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = 2'd0; rx_strobe = 1'b1; rx_byte = b;
    @(negedge clk);
    rd_en = 1'b0; rx_strobe = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    fifo_clr = 1'b1;
    @(negedge clk);
    fifo_clr = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 data_ready", {31'd0, data_ready}, 32'd0);
    rd(2'd1, v); check("R1 status", v, 32'd0);
    rd(2'd2, v); check("R1 error word", v, 32'd0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    push(8'hA1, 0, 0); check("R13 rx pulse", {31'd0, irq_rx_pulse}, 32'd1);
    push(8'hB2, 0, 0);
    push(8'hC3, 0, 0);
    check("R13 pulse single cycle", {31'd0, irq_rx_pulse}, 32'd1);
    @(negedge clk);
    check("R13 pulse gone", {31'd0, irq_rx_pulse}, 32'd0);
    rd(2'd1, v); check("R2 count", v, 32'd3);
    rd(2'd3, v); check("R13 line status", v, 32'd1);
    rd(2'd0, v); check("R2 first", v, 32'hA1);
    check("R6 ready remains", {31'd0, data_ready}, 32'd1);
    rd(2'd0, v); check("R2 second", v, 32'hB2);
    rd(2'd0, v); check("R2 third", v, 32'hC3);
    check("R6 ready cleared", {31'd0, data_ready}, 32'd0);
  endtask

  task automatic t_full();
    logic [31:0] v;
    for (int i = 0; i < DEPTH; i++) push(8'(8'h10 + i), 0, 0);
    rd(2'd1, v); check("R3 full word", v, 32'h100);
    push(8'h99, 0, 0);
    check("R4 err pulse", {31'd0, irq_err_pulse}, 32'd1);
    check("R4 rx pulse absent", {31'd0, irq_rx_pulse}, 32'd0);
    check("R4 ready stays", {31'd0, data_ready}, 32'd1);
    rd(2'd1, v); check("R10 status bit9", v, 32'h300);
    rd(2'd2, v); check("R4 overrun bit", v, 32'h1);
    rd(2'd1, v); check("R10 bit9 cleared", v, 32'h100);
    swap(8'hEE, v); check("R12 swap read", v, 32'h10);
    rd(2'd1, v); check("R12 still full", v, 32'h100);
    for (int i = 1; i < DEPTH; i++) begin
      rd(2'd0, v); check("R4 drain order", v, 32'(8'h10 + i));
    end
    rd(2'd0, v); check("R12 swapped byte", v, 32'hEE);
    check("R6 empty after drain", {31'd0, data_ready}, 32'd0);
  endtask

  task automatic t_underflow();
    logic [31:0] v;
    rd(2'd0, v);
    check("R5 zero data", v, 32'd0);
    check("R5 err pulse", {31'd0, irq_err_pulse}, 32'd1);
    rd(2'd2, v); check("R5 no error bit", v, 32'd0);
  endtask

  task automatic t_break();
    logic [31:0] v;
    @(negedge clk);
    brk_strobe = 1'b1; rx_strobe = 1'b1; rx_byte = 8'h77;
    @(negedge clk);
    brk_strobe = 1'b0; rx_strobe = 1'b0;
    check("R8 err pulse", {31'd0, irq_err_pulse}, 32'd1);
    check("R13 no rx pulse on break", {31'd0, irq_rx_pulse}, 32'd0);
    rd(2'd1, v); check("R8 one byte", v, 32'h201);
    rd(2'd0, v); check("R8 null byte", v, 32'd0);
    rd(2'd2, v); check("R8 break bit", v, 32'h8);
    rd(2'd2, v); check("R10 clear on read", v, 32'd0);
  endtask

  task automatic t_flags();
    logic [31:0] v;
    push(8'h11, 1, 0);
    check("R9 parity pulse", {31'd0, irq_err_pulse}, 32'd1);
    push(8'h22, 0, 1);
    rd(2'd2, v); check("R9 parity and frame", v, 32'h6);
    push(8'h33, 0, 1);
    rd(2'd2, v); check("R9 frame only", v, 32'h4);
    pulse_clr();
  endtask

  task automatic t_hold();
    logic [31:0] v;
    fifo_en = 1'b0;
    push(8'h5A, 0, 0);
    check("R7 ready set", {31'd0, data_ready}, 32'd1);
    check("R13 hold rx pulse", {31'd0, irq_rx_pulse}, 32'd1);
    rd(2'd1, v); check("R7 queue untouched", v, 32'd0);
    rd(2'd0, v); check("R7 hold data", v, 32'h5A);
    check("R7 ready cleared", {31'd0, data_ready}, 32'd0);
    check("R7 no underflow", {31'd0, irq_err_pulse}, 32'd0);
    fifo_en = 1'b1;
  endtask

  task automatic t_clr();
    logic [31:0] v;
    push(8'h01, 0, 0);
    push(8'h02, 0, 0);
    @(negedge clk);
    fifo_clr = 1'b1; rx_strobe = 1'b1; rx_byte = 8'h03;
    @(negedge clk);
    fifo_clr = 1'b0; rx_strobe = 1'b0;
    rd(2'd1, v); check("R11 emptied", v, 32'd0);
    check("R11 ready low", {31'd0, data_ready}, 32'd0);
    rd(2'd0, v); check("R11 read after clear", v, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_full();
    t_underflow();
    t_break();
    t_flags();
    t_hold();
    t_clr();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule